// File: doc/BRIEF.md
# Edge-Compensated Pulse Timestamp Unit

This block timestamps the rising edge of an external once-per-second style pulse. It does not latch a counter at the edge. Instead it keeps two counters that advance together on a shared prescaled tick:

- a free-running time base;
- an elapsed counter that restarts from zero on every rising edge of the synchronized input.

A host that polls now and then can rebuild the edge time afterwards by subtracting the elapsed count from the time base.

A poll is a single-cycle strobe. In that cycle the block takes the input level and both counters from one coherent pipeline stage, and compares the level with the level it saw at the previous poll. A change to high produces a stamp. A change to low only reports the change. Both kinds of change steer an optional echo output, which can be inverted. When no input is assigned, polls produce no events.

The input passes through a synchronizer of `SYNC_STAGES` flops, then through one alignment flop. Because of this, every stamp refers to the clock edge that lies `SYNC_STAGES + 1` clocks after the physical input rise. This is a fixed offset. The block documents it and does not correct it.

Top module: `pulse_stamp_unit`

## Requirements
- R1: After reset, `base_count`, `stamp`, `stamp_valid`, `level_changed` and `echo_out` are all zero.
- R2: `base_count` advances by exactly one every `PRESCALE` clocks (default 4) and wraps from all ones to zero.
- R3: The stamp reported for an assert event equals the `base_count` value that is shown in the cycle after the `SYNC_STAGES + 1` clock edge that follows the input rise (the third edge with the default of 2). When several rising edges occur between two polls, the latest one counts.
- R4: A poll gives `stamp_valid` = 1 only when the polled level is high and the previous polled level was low. A poll that sees an unchanged level gives `stamp_valid` = 0 and `level_changed` = 0.
- R5: A poll that sees a change from high to low gives `level_changed` = 1 and `stamp_valid` = 0, and leaves `stamp` at its previous value.
- R6: The echo state becomes 1 on an assert event and 0 on a fall event. `echo_out` equals the echo state XOR `echo_invert` while `echo_en` = 1, and is 0 while `echo_en` = 0.
- R7: While `pin_assigned` = 0, polls report no events and do not update the remembered level. A rising edge that arrives during that time is still measured.
- R8: `stamp`, `stamp_valid` and `level_changed` hold their values between polls, whatever the input does.
- R9: The stamp is correct modulo 2^`CNT_W` when the time base wraps between the edge and the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | External pulse, asynchronous |
| pin_assigned | input | 1 | 1 when an input pin is assigned to the unit |
| echo_en | input | 1 | Enables the echo output |
| echo_invert | input | 1 | Inverts the echo output |
| poll | input | 1 | Single-cycle poll strobe |
| base_count | output | CNT_W | Free-running time base |
| stamp_valid | output | 1 | Last poll produced an assert stamp |
| level_changed | output | 1 | Last poll saw a level change |
| stamp | output | CNT_W | Compensated edge time |
| echo_out | output | 1 | Echo of the pulse state |

## Verification
The stamp is tried in four situations:

- a single isolated rise, which shows that the synchronizer latency and the subtraction line up;
- a rise, a fall and a second rise between two polls, which separates the latest edge from the earliest;
- a rise while unassigned, which shows that measuring goes on while reporting is gated;
- a rise just before the time base wraps, which separates modulo arithmetic from a saturating or sign-extended result.

Repeated polls on an unchanged level, and changes to the input between polls, separate event detection from level detection. Toggling the echo configuration shows that the echo state and the output polarity are independent.

// File: rtl/pstamp_pkg.sv
package pstamp_pkg;

   typedef enum logic [1:0] {
      EV_NONE   = 2'd0,
      EV_ASSERT = 2'd1,
      EV_CLEAR  = 2'd2
   } pstamp_event_e;

   // classify a poll from the remembered and the current level
   function automatic pstamp_event_e classify(input logic assigned,
                                              input logic prev_lvl,
                                              input logic now_lvl);
      pstamp_event_e ev;
      ev = EV_NONE;
      if (assigned && (prev_lvl != now_lvl))
         ev = now_lvl ? EV_ASSERT : EV_CLEAR;
      return ev;
   endfunction

endpackage

// File: rtl/pstamp_prescale.sv
module pstamp_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit POW2 = (DIV > 1) && ((DIV & (DIV - 1)) == 0);

   if (DIV < 1) begin : g_bad_div
      $error("pstamp_prescale: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick = 1'b1;
   end else if (POW2) begin : g_pow2
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cnt_q <= '0;
         else        cnt_q <= cnt_q + 1'b1;
      end
      assign tick = &cnt_q;

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end else begin : g_modulo
      logic [PW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      cnt_q <= '0;
         else if (cnt_q == PW'(DIV - 1))  cnt_q <= '0;
         else                             cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == PW'(DIV - 1));

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/pstamp_sync.sv
module pstamp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pstamp_sync: STAGES must be at least 2");
   end

   // STAGES synchronizer flops plus one alignment flop
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
   assign level = sh_q[STAGES];

   // R3
   rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> level);
endmodule

// File: rtl/pstamp_counters.sv
module pstamp_counters #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clear,
   output logic [W-1:0] base,
   output logic [W-1:0] elapsed
);
   if (W < 2) begin : g_bad_w
      $error("pstamp_counters: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    base <= '0;
      else if (tick) base <= base + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     elapsed <= '0;
      else if (clear) elapsed <= '0;
      else if (tick)  elapsed <= elapsed + 1'b1;
   end

   // R3
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (elapsed == '0));

   // R2
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(base));

   // R9
   diff_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((base - elapsed) == $past(base - elapsed)));
endmodule

// File: rtl/pstamp_poll.sv
module pstamp_poll
   import pstamp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         poll,
   input  logic         assigned,
   input  logic         level,
   input  logic [W-1:0] base,
   input  logic [W-1:0] elapsed,
   output logic         stamp_valid,
   output logic         level_changed,
   output logic [W-1:0] stamp,
   output logic         echo_state
);
   logic          prev_q;
   pstamp_event_e ev;

   assign ev = classify(assigned, prev_q, level);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q        <= 1'b0;
         stamp_valid   <= 1'b0;
         level_changed <= 1'b0;
         stamp         <= '0;
         echo_state    <= 1'b0;
      end else if (poll) begin
         if (assigned) prev_q <= level;
         stamp_valid   <= (ev == EV_ASSERT);
         level_changed <= (ev != EV_NONE);
         if (ev == EV_ASSERT) begin
            stamp      <= base - elapsed;
            echo_state <= 1'b1;
         end else if (ev == EV_CLEAR) begin
            echo_state <= 1'b0;
         end
      end
   end

   // R4
   valid_changed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_valid |-> level_changed);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !poll |=> ($stable(stamp) && $stable(stamp_valid) && $stable(level_changed)));

   // R7
   unassigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll && !assigned) |=> (!level_changed && !stamp_valid));

   // R6
   echo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stamp_valid |-> echo_state);
endmodule

// File: rtl/pulse_stamp_unit.sv
module pulse_stamp_unit #(
   parameter int CNT_W       = 16,
   parameter int PRESCALE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pulse_in,
   input  logic             pin_assigned,
   input  logic             echo_en,
   input  logic             echo_invert,
   input  logic             poll,
   output logic [CNT_W-1:0] base_count,
   output logic             stamp_valid,
   output logic             level_changed,
   output logic [CNT_W-1:0] stamp,
   output logic             echo_out
);
   logic             tick;
   logic             lvl;
   logic             rise;
   logic [CNT_W-1:0] elapsed;
   logic             echo_state;

   pstamp_prescale #(.DIV(PRESCALE)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   pstamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pulse_in),
      .level(lvl),
      .rise (rise)
   );

   pstamp_counters #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .clear  (rise),
      .base   (base_count),
      .elapsed(elapsed)
   );

   pstamp_poll #(.W(CNT_W)) u_poll (
      .clk          (clk),
      .rst_n        (rst_n),
      .poll         (poll),
      .assigned     (pin_assigned),
      .level        (lvl),
      .base         (base_count),
      .elapsed      (elapsed),
      .stamp_valid  (stamp_valid),
      .level_changed(level_changed),
      .stamp        (stamp),
      .echo_state   (echo_state)
   );

   assign echo_out = echo_en & (echo_state ^ echo_invert);

   // R3
   coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lvl)) |-> (elapsed == '0));
endmodule

// File: tb/sim_pulse_stamp_unit.sv
module sim_pulse_stamp_unit;
   localparam int TW  = 12;
   localparam int PRE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pulse_in = 1'b0;
   logic          pin_assigned = 1'b1;
   logic          echo_en = 1'b1;
   logic          echo_invert = 1'b0;
   logic          poll = 1'b0;
   logic [TW-1:0] base_count;
   logic          stamp_valid;
   logic          level_changed;
   logic [TW-1:0] stamp;
   logic          echo_out;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pulse_stamp_unit #(.CNT_W(TW), .PRESCALE(PRE), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .pin_assigned(pin_assigned),
      .echo_en(echo_en), .echo_invert(echo_invert), .poll(poll),
      .base_count(base_count), .stamp_valid(stamp_valid),
      .level_changed(level_changed), .stamp(stamp), .echo_out(echo_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_poll();
      @(negedge clk) poll = 1'b1;
      @(negedge clk) poll = 1'b0;
   endtask

   // raise input, return base value seen once the edge has been taken
   task automatic raise_in(output logic [TW-1:0] exp);
      @(negedge clk) pulse_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk) exp = base_count;
   endtask

   task automatic lower_in();
      @(negedge clk) pulse_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(base_count == 0, "R1 base", base_count, 0);
      chk(stamp == 0 && !stamp_valid && !level_changed, "R1 outputs",
          {stamp_valid, level_changed}, 0);
      chk(echo_out == 0, "R1 echo", echo_out, 0);
   endtask

   task automatic t_rate();
      logic [TW-1:0] b0;
      @(negedge clk) b0 = base_count;
      repeat (10 * PRE) @(negedge clk);
      chk(base_count == TW'(b0 + 10), "R2 rate", base_count, TW'(b0 + 10));
   endtask

   task automatic t_assert(output logic [TW-1:0] exp);
      raise_in(exp);
      repeat (17) @(negedge clk);
      do_poll();
      chk(stamp_valid && level_changed, "R4 assert event",
          {stamp_valid, level_changed}, 3);
      chk(stamp == exp, "R3 stamp", stamp, exp);
      chk(echo_out == 1, "R6 echo set", echo_out, 1);
   endtask

   task automatic t_hold(input logic [TW-1:0] exp);
      lower_in();
      repeat (20) @(negedge clk);
      chk(stamp == exp && stamp_valid && level_changed, "R8 hold", stamp, exp);
   endtask

   task automatic t_fall(input logic [TW-1:0] exp);
      do_poll();
      chk(level_changed && !stamp_valid, "R5 fall event",
          {stamp_valid, level_changed}, 1);
      chk(stamp == exp, "R5 stamp kept", stamp, exp);
      chk(echo_out == 0, "R6 echo clear", echo_out, 0);
      @(negedge clk) echo_invert = 1'b1;
      #1 chk(echo_out == 1, "R6 echo invert", echo_out, 1);
      echo_en = 1'b0;
      #1 chk(echo_out == 0, "R6 echo disabled", echo_out, 0);
      echo_en = 1'b1; echo_invert = 1'b0;
   endtask

   task automatic t_repeat();
      do_poll();
      chk(!level_changed && !stamp_valid, "R4 no change",
          {stamp_valid, level_changed}, 0);
   endtask

   task automatic t_double();
      logic [TW-1:0] e1, e2;
      raise_in(e1);
      repeat (9) @(negedge clk);
      lower_in();
      repeat (7) @(negedge clk);
      raise_in(e2);
      repeat (11) @(negedge clk);
      do_poll();
      chk(stamp_valid && stamp == e2, "R3 latest edge", stamp, e2);
      lower_in();
      do_poll();
   endtask

   task automatic t_unassigned();
      logic [TW-1:0] e;
      @(negedge clk) pin_assigned = 1'b0;
      raise_in(e);
      repeat (6) @(negedge clk);
      do_poll();
      chk(!level_changed && !stamp_valid, "R7 no event",
          {stamp_valid, level_changed}, 0);
      @(negedge clk) pin_assigned = 1'b1;
      repeat (5) @(negedge clk);
      do_poll();
      chk(stamp_valid && stamp == e, "R7 level kept", stamp, e);
      lower_in();
      do_poll();
   endtask

   task automatic t_wrap();
      logic [TW-1:0] e;
      while (base_count != {TW{1'b1}}) @(negedge clk);
      repeat (PRE) @(negedge clk);
      chk(base_count == 0, "R2 wrap", base_count, 0);
      while (base_count != TW'({TW{1'b1}} - 1)) @(negedge clk);
      raise_in(e);
      repeat (40) @(negedge clk);
      do_poll();
      chk(base_count < e, "R9 wrapped", base_count, e);
      chk(stamp_valid && stamp == e, "R9 modulo stamp", stamp, e);
   endtask

   initial begin
      logic [TW-1:0] exp;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_rate();
      t_assert(exp);
      t_hold(exp);
      t_fall(exp);
      t_repeat();
      t_double();
      t_unassigned();
      t_wrap();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule